// File: doc/BRIEF.md
# Inter-Core Send Command Decoder

This block sits behind the three send registers of a core's inter-processor doorbell logic. Software writes a 64-bit command together with a command-type select: ring a doorbell vector, deposit a word into a mailbox, or write a word at an arbitrary register offset. The block checks that the named target core exists and turns the command into requests on a shared port toward the per-core register blocks. The target register blocks answer each request. When the command is finished, the block raises a one-cycle done pulse with an error flag.

Word writes carry a 4-bit keep mask. Each set bit protects one byte of the word already in the target, and the command supplies the remaining bytes. A zero mask gives a single plain write. A non-zero mask makes the block read the old word first, merge the bytes and write the result back. A failed read abandons the command without writing.

The command input is valid/ready. The block accepts a command only while idle and holds `cmd_ready` low until that command's done pulse has gone, so commands complete strictly one at a time. The request output is also valid/ready. While `req_ready` is low the request stays on the port unchanged, and the block counts it as issued only on the cycle that `req_valid` and `req_ready` are both high. A response is taken on any cycle that `rsp_valid` is high while the block waits for it.

Top module: `ipi_send_decoder`

## Requirements
- R1: The target core is `cmd_data[25:16]`. If it is not below `NUM_CORES`, the block issues no request and pulses `done_valid` with `done_err`=1 in the cycle after acceptance.
- R2: A doorbell command (`cmd_kind`=0) issues exactly one set-bits request (`req_op`=2) at address 0x0000 with `req_wdata` = 1 << `cmd_data[4:0]`. The target ORs this value into its status word, and no read is issued.
- R3: A mailbox command (`cmd_kind`=1) targets address 0x20 + 4*`cmd_data[4:2]` with new data `cmd_data[63:32]`.
- R4: An offset command (`cmd_kind`=2) targets address `cmd_data[15:0]` with new data `cmd_data[63:32]`.
- R5: For kinds 1 and 2 with keep mask `cmd_data[30:27]` equal to zero, exactly one write request (`req_op`=1) is issued and no read.
- R6: With a non-zero keep mask, a read request (`req_op`=0) precedes the write. In the written word, byte i comes from the old word when `cmd_data[27+i]` is 1 and from the new data otherwise.
- R7: If the read response carries `rsp_err`=1, no write is issued and the done pulse carries `done_err`=1.
- R8: The error flag of the final write or set response is reported as `done_err`.
- R9: `cmd_ready` is high only while idle. `done_valid` lasts one cycle and is followed by idle.
- R10: A command with `cmd_kind`=3 issues no request and completes with `done_err`=1 in the cycle after acceptance.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_core`, `req_addr`, `req_op` and `req_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_kind | input | 2 | 0 doorbell, 1 mailbox, 2 offset write, 3 reserved |
| cmd_data | input | 64 | Send command word |
| req_valid | output | 1 | Request to a target register block |
| req_ready | input | 1 | Target takes the request |
| req_core | output | 10 | Target core index |
| req_addr | output | 16 | Register offset in the target |
| req_op | output | 2 | 0 read, 1 write, 2 set status bits |
| req_wdata | output | 32 | Write data or bits to set |
| rsp_valid | input | 1 | Response from the target |
| rsp_err | input | 1 | Target reports failure |
| rsp_rdata | input | 32 | Read data |
| done_valid | output | 1 | Command finished (one cycle) |
| done_err | output | 1 | Command failed; meaningful with done_valid |

## Verification
The bench counts cycles from the accepting edge to the done pulse. Its target model answers one cycle after it accepts each request, and it holds off `req_ready` for G cycles per request. Under that model the pulse is due 1 cycle after acceptance for a rejected command, 3+G cycles for a set or a plain write, 3+G for a failed read, and 5+2G for a read-merge-write. The bench samples every output on the falling edge and checks the pulse at exactly that count. On every falling edge before the pulse it also checks that `cmd_ready` is low. The target word, the status word and the per-kind request counts are compared only after the pulse, when every request of the command has completed.

// File: rtl/ipi_dec_pkg.sv
package ipi_dec_pkg;
  localparam int CMD_W  = 64;
  localparam int CORE_W = 10;
  localparam int ADDR_W = 16;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    KIND_BELL = 2'd0,
    KIND_MBOX = 2'd1,
    KIND_OFFS = 2'd2,
    KIND_RSVD = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_WRITE = 2'd1,
    OP_SETBITS = 2'd2
  } req_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT, S_FIN
  } seq_state_e;

  typedef struct packed {
    logic              tgt_ok;
    logic              is_set;
    logic [CORE_W-1:0] core;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] data;
    logic [LANES-1:0]  keep;
  } plan_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_dec_pkg::*;
#(
  parameter int                NUM_CORES   = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h0000,
  parameter logic [ADDR_W-1:0] MBOX_BASE   = 16'h0020
) (
  input  logic [1:0]       kind,
  input  logic [CMD_W-1:0] cmd,
  output plan_t            plan
);
  localparam int CORE_LSB = 16;
  localparam int KEEP_LSB = 27;
  localparam int DATA_LSB = 32;

  logic [CORE_W-1:0] core_id;
  logic              core_ok;
  logic              kind_ok;

  assign core_id = cmd[CORE_LSB +: CORE_W];
  assign core_ok = 32'(core_id) < 32'(NUM_CORES);
  assign kind_ok = kind != KIND_RSVD;

  always_comb begin
    plan        = '0;
    plan.tgt_ok = core_ok && kind_ok;
    plan.core   = core_id;
    plan.is_set = kind == KIND_BELL;
    case (kind)
      KIND_BELL: begin
        plan.addr = STATUS_ADDR;
        plan.data = WORD_W'(1) << cmd[4:0];
        plan.keep = '0;
      end
      KIND_MBOX: begin
        plan.addr = MBOX_BASE + ADDR_W'({cmd[4:2], 2'b00});
        plan.data = cmd[DATA_LSB +: WORD_W];
        plan.keep = cmd[KEEP_LSB +: LANES];
      end
      KIND_OFFS: begin
        plan.addr = cmd[ADDR_W-1:0];
        plan.data = cmd[DATA_LSB +: WORD_W];
        plan.keep = cmd[KEEP_LSB +: LANES];
      end
      default: begin
        plan.addr = '0;
        plan.data = '0;
        plan.keep = '0;
      end
    endcase
  end
endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge
  import ipi_dec_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] new_word,
  input  logic [LANES-1:0]  keep,
  output logic [WORD_W-1:0] merged
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*8 +: 8] = keep[i] ? old_word[i*8 +: 8] : new_word[i*8 +: 8];
  end
endmodule

// File: rtl/ipi_cmd_seq.sv
module ipi_cmd_seq
  import ipi_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  plan_t             plan,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CORE_W-1:0] req_core,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_op,
  output logic [WORD_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [WORD_W-1:0] rsp_rdata,
  output logic              done_valid,
  output logic              done_err
);
  seq_state_e        state;
  plan_t             plan_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] merged;
  logic              err_q;

  ipi_byte_merge u_merge (
    .old_word (rsp_rdata),
    .new_word (word_q),
    .keep     (plan_q.keep),
    .merged   (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      plan_q <= '0;
      word_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          plan_q <= plan;
          word_q <= plan.data;
          err_q  <= !plan.tgt_ok;
          if (!plan.tgt_ok)          state <= S_FIN;
          else if (plan.keep != '0) state <= S_RD_REQ;
          else                       state <= S_WR_REQ;
        end
        S_RD_REQ: if (req_ready) state <= S_RD_WAIT;
        S_RD_WAIT: if (rsp_valid) begin
          if (rsp_err) begin
            err_q <= 1'b1;
            state <= S_FIN;
          end else begin
            word_q <= merged;
            state  <= S_WR_REQ;
          end
        end
        S_WR_REQ: if (req_ready) state <= S_WR_WAIT;
        S_WR_WAIT: if (rsp_valid) begin
          err_q <= rsp_err;
          state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready  = state == S_IDLE;
    req_valid  = (state == S_RD_REQ) || (state == S_WR_REQ);
    req_core   = plan_q.core;
    req_addr   = plan_q.addr;
    req_wdata  = word_q;
    if (state == S_RD_REQ)  req_op = OP_READ;
    else if (plan_q.is_set) req_op = OP_SETBITS;
    else                    req_op = OP_WRITE;
    done_valid = state == S_FIN;
    done_err   = (state == S_FIN) && err_q;
  end
endmodule

// File: rtl/ipi_send_decoder.sv
module ipi_send_decoder
  import ipi_dec_pkg::*;
#(
  parameter int                NUM_CORES   = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h0000,
  parameter logic [ADDR_W-1:0] MBOX_BASE   = 16'h0020
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_kind,
  input  logic [63:0] cmd_data,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [9:0]  req_core,
  output logic [15:0] req_addr,
  output logic [1:0]  req_op,
  output logic [31:0] req_wdata,
  input  logic        rsp_valid,
  input  logic        rsp_err,
  input  logic [31:0] rsp_rdata,
  output logic        done_valid,
  output logic        done_err
);
  plan_t plan;

  ipi_cmd_decode #(
    .NUM_CORES   (NUM_CORES),
    .STATUS_ADDR (STATUS_ADDR),
    .MBOX_BASE   (MBOX_BASE)
  ) u_decode (
    .kind (cmd_kind),
    .cmd  (cmd_data),
    .plan (plan)
  );

  ipi_cmd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .plan       (plan),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_core   (req_core),
    .req_addr   (req_addr),
    .req_op     (req_op),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .done_valid (done_valid),
    .done_err   (done_err)
  );
endmodule

// File: rtl/ipi_send_decoder_chk.sv
module ipi_send_decoder_chk #(
  parameter int NUM_CORES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_kind,
  input logic [63:0] cmd_data,
  input logic        req_valid,
  input logic        req_ready,
  input logic [9:0]  req_core,
  input logic [15:0] req_addr,
  input logic [1:0]  req_op,
  input logic [31:0] req_wdata,
  input logic        done_valid,
  input logic        done_err
);
  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid || done_valid) |-> !cmd_ready);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && cmd_ready));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_core) && $stable(req_addr)
                                   && $stable(req_op) && $stable(req_wdata)));

  assert_bad_core_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (32'(cmd_data[25:16]) >= 32'(NUM_CORES)))
      |=> (done_valid && done_err && !req_valid));

  assert_reserved_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == 2'd3) |=> (done_valid && done_err && !req_valid));

  assert_core_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (32'(req_core) < 32'(NUM_CORES)));

  assert_one_bit_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2) |-> ($countones(req_wdata) == 1 && req_addr == 16'h0000));
endmodule

bind ipi_send_decoder ipi_send_decoder_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_kind   (cmd_kind),
  .cmd_data   (cmd_data),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_core   (req_core),
  .req_addr   (req_addr),
  .req_op     (req_op),
  .req_wdata  (req_wdata),
  .done_valid (done_valid),
  .done_err   (done_err)
);

// File: tb/ipi_send_decoder_test.sv
module ipi_send_decoder_test;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_kind = 2'd0;
  logic [63:0] cmd_data = '0;
  logic        req_valid;
  logic        req_ready;
  logic [9:0]  req_core;
  logic [15:0] req_addr;
  logic [1:0]  req_op;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        done_valid;
  logic        done_err;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  ipi_send_decoder #(.NUM_CORES(NC)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_data(cmd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core), .req_addr(req_addr),
    .req_op(req_op), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .done_valid(done_valid), .done_err(done_err)
  );

  // Target register model: word store, status words, stall gap, fault injection.
  logic [31:0] mem  [NC][16];
  logic [31:0] stat [NC];
  int gap = 0;
  int gcnt = 0;
  int nrd = 0, nwr = 0, nset = 0;
  logic rd_fail = 1'b0, wr_fail = 1'b0;

  function automatic logic [31:0] init_word(int c, int w);
    return 32'hA5C3_0000 ^ 32'(c << 12) ^ 32'(w * 32'h0101_0011);
  endfunction

  assign req_ready = req_valid && (gcnt == 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        stat[c] <= '0;
        for (int w = 0; w < 16; w++) mem[c][w] <= init_word(c, w);
      end
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
      gcnt <= gap;
    end else begin
      if (!req_valid) gcnt <= gap;
      else if (gcnt != 0) gcnt <= gcnt - 1;
      else gcnt <= gap;
      rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= mem[req_core[1:0]][req_addr[5:2]];
        if (req_op == 2'd0) begin
          nrd <= nrd + 1;
          rsp_err <= rd_fail;
        end else begin
          rsp_err <= wr_fail;
          if (req_op == 2'd2) begin
            nset <= nset + 1;
            if (!wr_fail) stat[req_core[1:0]] <= stat[req_core[1:0]] | req_wdata;
          end else begin
            nwr <= nwr + 1;
            if (!wr_fail) mem[req_core[1:0]][req_addr[5:2]] <= req_wdata;
          end
        end
      end
    end
  end

  logic [31:0] xmem  [NC][16];
  logic [31:0] xstat [NC];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_vec(input logic [1:0] k, input logic [63:0] d, input int g);
    int core = int'(d[25:16]);
    bit ok_tgt = (k != 2'd3) && (core < NC);
    logic [3:0] keep = d[30:27];
    logic [31:0] nd = d[63:32];
    logic [15:0] a = (k == 2'd1) ? 16'(16'h20 + 4 * int'(d[4:2])) : d[15:0];
    int widx = int'(a[5:2]);
    bit exp_err; int exp_lat; int e_rd = 0, e_wr = 0, e_set = 0;
    string tag;
    logic [31:0] exp_val, act_val, kmask, old;
    int rd0, wr0, set0, n;
    bit busy_ok;

    gap = g;
    if (k == 2'd3) begin tag = "R10"; exp_err = 1; exp_lat = 1; end
    else if (!ok_tgt) begin tag = "R1"; exp_err = 1; exp_lat = 1; end
    else if (k == 2'd0) begin
      tag = wr_fail ? "R8" : "R2";
      exp_err = wr_fail; exp_lat = 3 + g; e_set = 1;
      if (!wr_fail) xstat[core] = xstat[core] | (32'd1 << d[4:0]);
    end else if (keep == 4'd0) begin
      tag = wr_fail ? "R8" : "R5";
      exp_err = wr_fail; exp_lat = 3 + g; e_wr = 1;
      if (!wr_fail) xmem[core][widx] = nd;
    end else if (rd_fail) begin
      tag = "R7"; exp_err = 1; exp_lat = 3 + g; e_rd = 1;
    end else begin
      tag = wr_fail ? "R8" : "R6";
      exp_err = wr_fail; exp_lat = 5 + 2 * g; e_rd = 1; e_wr = 1;
      kmask = '0;
      for (int i = 0; i < 4; i++) if (keep[i]) kmask[i*8 +: 8] = 8'hFF;
      old = xmem[core][widx];
      if (!wr_fail) xmem[core][widx] = (old & kmask) | (nd & ~kmask);
    end

    @(negedge clk);
    rd0 = nrd; wr0 = nwr; set0 = nset;
    cmd_kind = k; cmd_data = d; cmd_valid = 1'b1;
    @(posedge clk);
    n = 0; busy_ok = 1;
    forever begin
      @(negedge clk);
      n++;
      cmd_valid = 1'b0;
      if (done_valid || n > 60) break;
      if (cmd_ready) busy_ok = 0;
    end
    chk(done_valid && n == exp_lat, (g > 0 && exp_lat > 1) ? "R11" : tag, "done latency",
        n, exp_lat);
    chk(done_err == exp_err, tag, "done_err", done_err, exp_err);
    chk(busy_ok, "R9", "cmd_ready low while busy", busy_ok, 1);
    chk((nrd - rd0) == e_rd && (nwr - wr0) == e_wr && (nset - set0) == e_set, tag,
        "request counts rd/wr/set", (nrd - rd0) * 256 + (nwr - wr0) * 16 + (nset - set0),
        e_rd * 256 + e_wr * 16 + e_set);
    if (ok_tgt) begin
      if (k == 2'd0) begin act_val = stat[core]; exp_val = xstat[core]; end
      else begin act_val = mem[core][widx]; exp_val = xmem[core][widx]; end
      chk(act_val == exp_val, (k == 2'd1) ? "R3" : (k == 2'd2) ? "R4" : tag,
          "target word", act_val, exp_val);
    end
    @(negedge clk);
    chk(cmd_ready && !done_valid, "R9", "idle after done", cmd_ready, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      xstat[c] = '0;
      for (int w = 0; w < 16; w++) xmem[c][w] = init_word(c, w);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !req_valid && !done_valid, "R9", "reset state",
        {cmd_ready, req_valid, done_valid}, 3'b100);

    for (int c = 0; c < NC + 2; c++) begin
      for (int m = 0; m < 4; m++)
        do_vec(2'd0, {32'hDEAD_BEEF, 6'd0, 10'(c), 11'd0, 5'((c * 7 + m * 9) % 32)}, m % 3);
      for (int m = 0; m < 16; m++)
        do_vec(2'd1, {32'(32'h1122_3344 * (m + 1) + c), 1'b0, 4'(m), 1'b0, 10'(c), 11'd0,
                      3'(m % 8), 2'b11}, m % 3);
      for (int m = 0; m < 16; m++)
        do_vec(2'd2, {32'(32'h9E37_79B9 * (m + 3) ^ c), 1'b1, 4'(15 - m), 1'b0, 10'(c),
                      16'(((m * 5) % 16) * 4)}, (m + 1) % 3);
      do_vec(2'd3, {32'h0, 6'd0, 10'(c), 16'h0024}, 0);
    end

    rd_fail = 1'b1;
    for (int m = 0; m < 16; m++)
      do_vec(2'd1, {32'hCAFE_0000 + 32'(m), 1'b0, 4'(m), 1'b0, 10'(m % NC), 11'd0,
                    3'(m % 8), 2'b00}, m % 2);
    rd_fail = 1'b0;
    wr_fail = 1'b1;
    for (int m = 0; m < 8; m++) begin
      do_vec(2'd2, {32'h0F0F_0000 + 32'(m), 1'b0, 4'(m), 1'b0, 10'(m % NC), 16'(m * 8)}, 0);
      do_vec(2'd0, {32'h0, 6'd0, 10'(m % NC), 11'd0, 5'(m + 20)}, 1);
    end
    wr_fail = 1'b0;
    do_vec(2'd1, {32'h0, 1'b0, 4'd0, 1'b0, 10'h3FF, 16'h0}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule